// File: doc/BRIEF.md
# Timer Input Capture Unit

The unit watches a single asynchronous capture pin and records a time stamp each time a qualifying edge arrives. Edge qualification is chosen by a 3-bit mode: falling only, rising only, every edge, every edge after a selectable first edge, every 4th or every 16th rising edge, or a flag-only setting that raises the interrupt flag on a rising edge without storing anything. The time stamp is taken from one of two free-running 16-bit counters supplied as inputs, or from both joined into one 32-bit value.

Stamps enter a 4-entry first-in first-out store that software drains one entry per read pulse. A sticky interrupt flag rises once the store holds a programmable number of entries, and it stays up until a clear pulse arrives. A capture that finds the store full is discarded, and an overflow indication records this until the next read.

Top module: `capture_unit`

## Requirements
- R1: After reset, not_empty, overflow and irq_flag are 0 and rd_data is 0.
- R2: In mode 3'b011, each rising edge of the pin stores a stamp and falling edges store nothing.
- R3: In mode 3'b010, each falling edge stores a stamp and rising edges store nothing.
- R4: In mode 3'b001, every edge of either polarity stores a stamp.
- R5: In mode 3'b110, the first stored edge is a rising edge when first_rise is 1 and a falling edge when it is 0. Earlier edges of the other polarity are ignored, and after the first capture every edge is stored.
- R6: Mode 3'b100 stores on every 4th rising edge and mode 3'b101 on every 16th rising edge, counted from entry into the mode.
- R7: The stamp is {tmr_b, tmr_a} when tb_join is 1. Otherwise it is tmr_b when tb_sel_b is 1 and tmr_a when tb_sel_b is 0, with the upper 16 bits zero.
- R8: The store keeps 4 entries in arrival order. A capture that arrives while the store is full is dropped and sets overflow, and overflow clears on the next read. rd_data shows the oldest entry, and rd_pop removes it.
- R9: irq_flag sets when a stored capture brings the fill level to irq_level+1 or more (codes 0..3 mean 1..4 entries). It stays set until an irq_clr pulse.
- R10: In mode 3'b111, a rising edge sets irq_flag and nothing is stored.
- R11: Mode 3'b000 empties the store, clears overflow, and stores nothing while it is selected.
- R12: Any change of mode restarts the prescale count and the first-edge state.
- R13: A pin change becomes visible as a stored entry (not_empty=1) just after the third rising clock edge that follows it, but not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_pin | input | 1 | Asynchronous capture pin |
| mode | input | 3 | Edge qualification mode |
| first_rise | input | 1 | First-edge polarity for mode 3'b110 (1 = rising) |
| tb_sel_b | input | 1 | Selects tmr_b instead of tmr_a as the 16-bit time base |
| tb_join | input | 1 | Uses {tmr_b, tmr_a} as a 32-bit time base |
| irq_level | input | 2 | Fill level for the interrupt, minus one |
| tmr_a | input | 16 | First time-base counter value |
| tmr_b | input | 16 | Second time-base counter value |
| rd_pop | input | 1 | Removes the oldest entry |
| irq_clr | input | 1 | Clears irq_flag |
| rd_data | output | 32 | Oldest stored stamp |
| not_empty | output | 1 | At least one stored entry |
| overflow | output | 1 | A capture was dropped because the store was full |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The assertions assume that mode changes are held for at least one clock, that rd_pop is not raised while the store is empty unless the read is meant to be ignored, and that irq_clr is not pulsed in the same cycle as a capture that sets the flag. The stimulus changes mode only while the pin is stable, and it spaces pin edges four clocks apart so that every edge clears the synchronizer before the next arrives. It holds the timer inputs steady across each capture window, so each expected stamp is the value the bench put on the timer inputs before the edge.

// File: rtl/ecap_pkg.sv
// Shared definitions for the capture unit: mode encoding.
package ecap_pkg;
    typedef enum logic [2:0] {
        CM_OFF    = 3'b000,
        CM_BOTH   = 3'b001,
        CM_FALL   = 3'b010,
        CM_RISE   = 3'b011,
        CM_DIV_LO = 3'b100,
        CM_DIV_HI = 3'b101,
        CM_FIRST  = 3'b110,
        CM_FLAG   = 3'b111
    } cap_mode_e;
endpackage

// File: rtl/ecap_edge_qual.sv
// Synchronizes the capture pin, detects edges and decides per mode whether
// an edge stores a stamp or only raises the flag.
// Assumes: the pin is asynchronous; PRE_LO <= PRE_HI; a mode change suppresses
// events for one cycle while the prescale and first-edge state restart.
module ecap_edge_qual
    import ecap_pkg::*;
#(
    parameter int PRE_LO = 4,
    parameter int PRE_HI = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [2:0] mode_raw,
    input  logic       first_rise,
    output logic       store_evt,
    output logic       flag_evt
);
    localparam int PW = $clog2(PRE_HI);

    cap_mode_e       mode, mode_q;
    logic            s1, s2, prev_s;
    logic            rise, fall, mchg, div_mode, armed;
    logic [PW-1:0]   pcnt, lim_m1;

    assign mode = cap_mode_e'(mode_raw);

    // Two-flop synchronizer plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1     <= 1'b0;
            s2     <= 1'b0;
            prev_s <= 1'b0;
        end else begin
            s1     <= pin;
            s2     <= s1;
            prev_s <= s2;
        end
    end

    // Remembers the previous mode to spot changes.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= CM_OFF;
        else        mode_q <= mode;
    end

    assign rise = s2 & ~prev_s;
    assign fall = ~s2 & prev_s;
    assign mchg = (mode != mode_q);

    // Prescale limit for the active divide mode.
    always_comb begin
        div_mode = (mode == CM_DIV_LO) || (mode == CM_DIV_HI);
        lim_m1   = (mode == CM_DIV_HI) ? PW'(PRE_HI - 1) : PW'(PRE_LO - 1);
    end

    // Mode-dependent qualification of the detected edges.
    always_comb begin
        store_evt = 1'b0;
        flag_evt  = 1'b0;
        if (!mchg) begin
            case (mode)
                CM_BOTH:   store_evt = rise | fall;
                CM_FALL:   store_evt = fall;
                CM_RISE:   store_evt = rise;
                CM_DIV_LO,
                CM_DIV_HI: store_evt = rise && (pcnt == lim_m1);
                CM_FIRST:  store_evt = armed ? (rise | fall)
                                             : (first_rise ? rise : fall);
                CM_FLAG:   flag_evt  = rise;
                default:   store_evt = 1'b0;
            endcase
        end
    end

    // Prescale counter and first-edge state; both restart on a mode change.
    always_ff @(posedge clk) begin
        if (!rst_n || mchg || mode == CM_OFF) begin
            pcnt  <= '0;
            armed <= 1'b0;
        end else begin
            if (div_mode && rise)
                pcnt <= (pcnt == lim_m1) ? '0 : pcnt + 1'b1;
            if (mode == CM_FIRST && store_evt)
                armed <= 1'b1;
        end
    end

    assert_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_OFF) |-> (!store_evt && !flag_evt));

    assert_prescale_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_mode && !mchg) |-> (pcnt <= lim_m1));

    assert_armed_by_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(store_evt));

    assert_restart_on_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mchg |=> (pcnt == '0 && !armed));
endmodule

// File: rtl/ecap_tbsel.sv
// Forms the captured time stamp from two TW-bit counters.
// Assumes: join takes precedence over sel_hi.
module ecap_tbsel #(
    parameter int TW = 16
) (
    input  logic [TW-1:0]   tmr_lo,
    input  logic [TW-1:0]   tmr_hi,
    input  logic            sel_hi,
    input  logic            join_en,
    output logic [2*TW-1:0] stamp
);
    // Time-base selection: joined, or one counter zero-extended.
    always_comb begin
        if (join_en)     stamp = {tmr_hi, tmr_lo};
        else if (sel_hi) stamp = {{TW{1'b0}}, tmr_hi};
        else             stamp = {{TW{1'b0}}, tmr_lo};
    end
endmodule

// File: rtl/ecap_fifo.sv
// Small stamp store with drop-on-full and a sticky overflow indication.
// Assumes: DEPTH is a power of two (pointers wrap naturally); a push in the
// same cycle as a pop on a full store is accepted.
module ecap_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          not_empty,
    output logic          overflow,
    output logic          push_ok,
    output logic [$clog2(DEPTH+1)-1:0] level_nxt
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic [DW-1:0] slot_q [DEPTH];
    logic          pop_ok, full;

    assign full      = (cnt == CW'(DEPTH));
    assign pop_ok    = pop && (cnt != '0);
    assign push_ok   = push && !flush && (!full || pop_ok);
    assign level_nxt = cnt + CW'(push_ok) - CW'(pop_ok);

    // One storage register per slot, written when the write pointer hits it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)                             q <= '0;
            else if (push_ok && wptr == AW'(i))     q <= din;
        end
        assign slot_q[i] = q;
    end

    // Pointers, fill level and overflow tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr     <= '0;
            rptr     <= '0;
            cnt      <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok) wptr <= wptr + 1'b1;
            if (pop_ok)  rptr <= rptr + 1'b1;
            cnt <= level_nxt;
            if (pop_ok)                      overflow <= 1'b0;
            else if (push && full)           overflow <= 1'b1;
        end
    end

    assign dout      = slot_q[rptr];
    assign not_empty = (cnt != '0);

    assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (full && overflow));

    assert_empty_pop_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !not_empty && !push && !flush) |=> !not_empty);

    assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!not_empty && !overflow));
endmodule

// File: rtl/capture_unit.sv
// Top of the timer input capture unit: edge qualification, time-base
// selection, stamp store and sticky interrupt flag.
// Assumes: timer inputs are synchronous to clk; irq_clr loses to a same-cycle set.
module capture_unit
    import ecap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cap_pin,
    input  logic [2:0]  mode,
    input  logic        first_rise,
    input  logic        tb_sel_b,
    input  logic        tb_join,
    input  logic [1:0]  irq_level,
    input  logic [15:0] tmr_a,
    input  logic [15:0] tmr_b,
    input  logic        rd_pop,
    input  logic        irq_clr,
    output logic [31:0] rd_data,
    output logic        not_empty,
    output logic        overflow,
    output logic        irq_flag
);
    localparam int TW    = 16;
    localparam int DEPTH = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    logic            store_evt, flag_evt, push_ok, flush, irq_set;
    logic [2*TW-1:0] stamp;
    logic [CW-1:0]   level_nxt;

    assign flush = (cap_mode_e'(mode) == CM_OFF);

    ecap_edge_qual #(.PRE_LO(4), .PRE_HI(16)) u_qual (
        .clk(clk), .rst_n(rst_n), .pin(cap_pin), .mode_raw(mode),
        .first_rise(first_rise), .store_evt(store_evt), .flag_evt(flag_evt)
    );

    ecap_tbsel #(.TW(TW)) u_tb (
        .tmr_lo(tmr_a), .tmr_hi(tmr_b), .sel_hi(tb_sel_b),
        .join_en(tb_join), .stamp(stamp)
    );

    ecap_fifo #(.DW(2*TW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(store_evt),
        .pop(rd_pop), .din(stamp), .dout(rd_data), .not_empty(not_empty),
        .overflow(overflow), .push_ok(push_ok), .level_nxt(level_nxt)
    );

    assign irq_set = flag_evt || (push_ok && level_nxt > CW'(irq_level));

    // Sticky interrupt flag: set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_flag <= 1'b0;
        else if (irq_set) irq_flag <= 1'b1;
        else if (irq_clr) irq_flag <= 1'b0;
    end

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    assert_flag_only_no_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode_e'(mode) == CM_FLAG) |-> !push_ok);
endmodule

// File: tb/sim_capture_unit.sv
module sim_capture_unit;
    logic        clk = 1'b0;
    logic        rst_n, cap_pin, first_rise, tb_sel_b, tb_join, rd_pop, irq_clr;
    logic [2:0]  mode;
    logic [1:0]  irq_level;
    logic [15:0] tmr_a, tmr_b;
    logic [31:0] rd_data;
    logic        not_empty, overflow, irq_flag;

    int nchk = 0;
    int nfail = 0;
    logic [31:0] expv [0:31];
    int nq;
    logic [2:0] m;
    string tag;
    logic v;

    always #2 clk = ~clk;

    capture_unit u0 (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .mode(mode),
        .first_rise(first_rise), .tb_sel_b(tb_sel_b), .tb_join(tb_join),
        .irq_level(irq_level), .tmr_a(tmr_a), .tmr_b(tmr_b), .rd_pop(rd_pop),
        .irq_clr(irq_clr), .rd_data(rd_data), .not_empty(not_empty),
        .overflow(overflow), .irq_flag(irq_flag)
    );

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic edge_to(input logic lvl, input logic [15:0] ta);
        @(negedge clk);
        tmr_a   = ta;
        cap_pin = lvl;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse(input logic [15:0] ta);
        edge_to(1'b1, ta);
        edge_to(1'b0, ta);
    endtask

    task automatic pop_expect(input logic [31:0] exp, input string t);
        chk(t, {31'b0, not_empty}, 32'd1);
        chk(t, rd_data, exp);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic setmode(input logic [2:0] nm);
        @(negedge clk);
        mode = nm;
        repeat (2) @(negedge clk);
    endtask

    task automatic flush_all();
        @(negedge clk);
        mode    = 3'b000;
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain(input string t);
        for (int j = 0; j < nq; j++) pop_expect(expv[j], t);
        chk(t, {31'b0, not_empty}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired before all requirements were checked");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cap_pin = 1'b0; mode = 3'b000; first_rise = 1'b0;
        tb_sel_b = 1'b0; tb_join = 1'b0; irq_level = 2'd3;
        tmr_a = '0; tmr_b = '0; rd_pop = 1'b0; irq_clr = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 not_empty", {31'b0, not_empty}, 32'd0);
        chk("R1 overflow", {31'b0, overflow}, 32'd0);
        chk("R1 irq_flag", {31'b0, irq_flag}, 32'd0);
        chk("R1 rd_data", rd_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R13: latency of three clock edges from pin change to stored entry
        setmode(3'b011);
        tmr_a   = 16'h0042;
        cap_pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R13 after two edges", {31'b0, not_empty}, 32'd0);
        @(negedge clk);
        chk("R13 after three edges", {31'b0, not_empty}, 32'd1);
        pop_expect(32'h0042, "R13 stamp");
        edge_to(1'b0, 16'h0043);
        chk("R13 fall ignored", {31'b0, not_empty}, 32'd0);

        // R2, R3, R4: sweep of single-edge and every-edge modes
        for (int mi = 0; mi < 3; mi++) begin
            m   = (mi == 0) ? 3'b001 : (mi == 1) ? 3'b010 : 3'b011;
            tag = (mi == 0) ? "R4" : (mi == 1) ? "R3" : "R2";
            flush_all();
            setmode(m);
            nq = 0;
            for (int k = 0; k < 6; k++) begin
                v = (k % 2 == 0);
                edge_to(v, 16'h0100 * m + 16'(k));
                if (m == 3'b001 || (m == 3'b011 && v) || (m == 3'b010 && !v)) begin
                    expv[nq] = 32'h0100 * m + 32'(k);
                    nq++;
                end
            end
            if (nq > 4) nq = 4;
            drain(tag);
        end

        // R5: first-edge polarity sweep
        for (int fr = 0; fr < 2; fr++) begin
            flush_all();
            first_rise = fr[0];
            setmode(3'b110);
            nq = 0;
            for (int k = 0; k < 4; k++) begin
                v = (k % 2 == 0);
                edge_to(v, 16'h0600 + 16'(k));
                if (fr == 1 || k > 0) begin
                    expv[nq] = 32'h0600 + 32'(k);
                    nq++;
                end
            end
            drain("R5");
        end

        // R6: divide-by-4 and divide-by-16 prescaling
        for (int di = 0; di < 2; di++) begin
            int div;
            div = (di == 0) ? 4 : 16;
            flush_all();
            setmode((di == 0) ? 3'b100 : 3'b101);
            nq = 0;
            for (int k = 0; k < 2 * div; k++) begin
                pulse(16'(k));
                if ((k + 1) % div == 0 && nq < 4) begin
                    expv[nq] = 32'(k);
                    nq++;
                end
            end
            drain("R6");
        end

        // R12: a mode change restarts the prescale count
        flush_all();
        setmode(3'b100);
        pulse(16'd1);
        pulse(16'd2);
        setmode(3'b101);
        setmode(3'b100);
        pulse(16'd10);
        pulse(16'd11);
        pulse(16'd12);
        chk("R12 no early capture", {31'b0, not_empty}, 32'd0);
        pulse(16'd13);
        pop_expect(32'd13, "R12 fourth after restart");

        // R7: time-base selection
        flush_all();
        setmode(3'b011);
        tmr_b = 16'hABCD;
        for (int c = 0; c < 3; c++) begin
            tb_sel_b = (c == 1);
            tb_join  = (c == 2);
            pulse(16'h1234);
            pop_expect((c == 0) ? 32'h0000_1234 : (c == 1) ? 32'h0000_ABCD : 32'hABCD_1234, "R7");
        end
        tb_sel_b = 1'b0;
        tb_join  = 1'b0;

        // R8: order, drop on full, overflow until read
        flush_all();
        setmode(3'b011);
        for (int k = 0; k < 5; k++) pulse(16'h0050 + 16'(k));
        chk("R8 overflow set", {31'b0, overflow}, 32'd1);
        pop_expect(32'h50, "R8 oldest");
        chk("R8 overflow cleared by read", {31'b0, overflow}, 32'd0);
        pop_expect(32'h51, "R8 order");
        pop_expect(32'h52, "R8 order");
        pop_expect(32'h53, "R8 order");
        chk("R8 fifth dropped", {31'b0, not_empty}, 32'd0);

        // R9: interrupt threshold sweep
        for (int lv = 0; lv < 4; lv++) begin
            irq_level = 2'(lv);
            flush_all();
            setmode(3'b011);
            for (int k = 1; k <= 4; k++) begin
                pulse(16'(k));
                chk("R9 flag at level", {31'b0, irq_flag}, (k >= lv + 1) ? 32'd1 : 32'd0);
            end
            @(negedge clk);
            irq_clr = 1'b1;
            @(negedge clk);
            irq_clr = 1'b0;
            @(negedge clk);
            chk("R9 cleared", {31'b0, irq_flag}, 32'd0);
        end

        // R10: flag-only mode
        flush_all();
        setmode(3'b111);
        chk("R10 flag idle", {31'b0, irq_flag}, 32'd0);
        pulse(16'h0077);
        repeat (5) @(negedge clk);
        chk("R10 flag set and held", {31'b0, irq_flag}, 32'd1);
        chk("R10 nothing stored", {31'b0, not_empty}, 32'd0);

        // R11: off mode empties and stores nothing
        flush_all();
        irq_level = 2'd3;
        setmode(3'b011);
        pulse(16'd1);
        pulse(16'd2);
        chk("R11 filled", {31'b0, not_empty}, 32'd1);
        setmode(3'b000);
        chk("R11 emptied", {31'b0, not_empty}, 32'd0);
        pulse(16'd3);
        chk("R11 off stores nothing", {31'b0, not_empty}, 32'd0);
        setmode(3'b011);
        chk("R11 still empty", {31'b0, not_empty}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule